// File: doc/BRIEF.md
# Virtual Interrupt Aggregator Register Bank

This block holds a parameterized number of virtual interrupt groups, each 64 bits wide. Every group keeps one raw status word and one enable word. Software never writes either word directly. Each word has one address that sets bits on a written 1 and a second address that clears bits on a written 1. A fifth, read-only address returns the bitwise AND of enable and status.

Each group drives one level-sensitive interrupt line. The line is high while any masked bit of that group is 1. Hardware event inputs, one bit per status bit, can also raise raw status bits. The block answers a simple single-beat register access port, but only when that port's region-select code is 2. Read data is registered and appears in the cycle after the read.

Top module: `vint_aggregator`

## Requirements
- R1: After a synchronous active-low reset, every enable and status bit is 0, every `vint_out` bit is low and `rd_data` is 0.
- R2: An access whose `acc_region` is not 2 changes no state, and a read with such a region returns 0.
- R3: A write at group offset 0x00 sets each enable bit written as 1 and leaves bits written as 0 unchanged. Reads at offsets 0x00 and 0x08 both return the enable word.
- R4: A write at group offset 0x08 clears each enable bit written as 1 and never sets an enable bit.
- R5: A write at offset 0x10 sets raw status bits written as 1, and a write at offset 0x18 clears them. Reads at both offsets return the unmasked raw status.
- R6: A read at offset 0x20 returns enable AND status. Writes at 0x20 change nothing.
- R7: `vint_out[g]` is high exactly while the masked status of group g is nonzero. It follows a state change in the cycle after the clock edge that made the change.
- R8: An offset inside a group's window other than 0x00, 0x08, 0x10, 0x18 or 0x20 is reserved. This covers any address with bits [2:0] nonzero, bits [11:6] nonzero or bits [5:3] above 4. Writes to a reserved offset change nothing, and reads of one return 0.
- R9: The group index is address bits [19:12]. An index at or above `NUM_GROUPS` changes no state on a write, does not alias onto a lower group, and reads as 0.
- R10: A 1 on `evt_in[g*64+b]` sets status bit b of group g at that clock edge. When a software clear of the same bit lands in the same cycle, the event wins and the bit stays set.
- R11: `rd_data` carries the value read in the cycle after a valid read. In any cycle that follows no valid read, `rd_data` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| acc_valid | input | 1 | Register access request this cycle |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_region | input | 2 | Region select; the block answers only code 2 |
| acc_addr | input | 20 | Byte address: group in [19:12], register in [5:3] |
| acc_wdata | input | 64 | Write data |
| evt_in | input | NUM_GROUPS*64 | Per-bit hardware event pulses, group g at bits [g*64 +: 64] |
| rd_data | output | 64 | Registered read data |
| vint_out | output | NUM_GROUPS | Level-sensitive interrupt line per group |

## Verification
A corrupted enable or status bit shows up as a wrong `vint_out` level in the very next cycle, but only when the other word has that bit at 1. The bench therefore keeps both words of several groups partly populated, so that a single wrong bit changes a line level. Any stored bit that is still hidden from the lines becomes visible on `rd_data` one cycle after a read at its set, clear or masked offset. A reference model compares both outputs on every clock. Decode faults such as aliasing past `NUM_GROUPS`, accepting a reserved offset or ignoring the region code leave state behind, and that state appears on the next readback of the affected group.

// File: rtl/vint_pkg.sv
// Package: shared constants and the register-select encoding for the
// virtual interrupt aggregator. Assumes 64-bit groups on a byte address.
package vint_pkg;
    localparam int WORD_W     = 64;
    localparam int GRP_LSB    = 12;
    localparam int SEL_LSB    = 3;
    localparam int SEL_W      = 3;
    localparam logic [1:0] REGION_CODE = 2'd2;

    // Register select taken from address bits [5:3].
    typedef enum logic [SEL_W-1:0] {
        SEL_EN_SET = 3'd0,
        SEL_EN_CLR = 3'd1,
        SEL_ST_SET = 3'd2,
        SEL_ST_CLR = 3'd3,
        SEL_MASKED = 3'd4
    } reg_sel_e;
endpackage

// File: rtl/vint_decode.sv
// Address decoder: turns one access into a write hit or a read hit,
// a group field and a register select. Anything reserved, misaligned,
// out of range or in another region yields no hit.
// Assumes: accesses are single-beat and 64-bit aligned.
module vint_decode
    import vint_pkg::*;
#(
    parameter int NUM_GROUPS = 4,
    parameter int ADDR_W     = 20,
    localparam int GRP_W     = ADDR_W - GRP_LSB
) (
    input  logic              acc_valid,
    input  logic              acc_write,
    input  logic [1:0]        acc_region,
    input  logic [ADDR_W-1:0] acc_addr,
    output logic              wr_hit,
    output logic              rd_hit,
    output logic [GRP_W-1:0]  grp_field,
    output reg_sel_e          sel
);
    logic addr_ok;
    logic grp_ok;
    logic hit;

    // Purpose: qualify the address, group range and region of the access.
    always_comb begin
        grp_field = acc_addr[ADDR_W-1:GRP_LSB];
        sel       = reg_sel_e'(acc_addr[SEL_LSB +: SEL_W]);
        addr_ok   = (acc_addr[SEL_LSB-1:0] == '0)
                 && (acc_addr[GRP_LSB-1:SEL_LSB+SEL_W] == '0)
                 && (acc_addr[SEL_LSB +: SEL_W] <= 3'd4);
        grp_ok    = int'(grp_field) < NUM_GROUPS;
        hit       = acc_valid && (acc_region == REGION_CODE) && addr_ok && grp_ok;
        wr_hit    = hit && acc_write;
        rd_hit    = hit && !acc_write;
    end
endmodule

// File: rtl/vint_group.sv
// One virtual interrupt group: enable and raw status words with
// set/clear write semantics, event inputs, and a level interrupt.
// Assumes: wr_en is already qualified by region, address and group.
module vint_group
    import vint_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  reg_sel_e          sel,
    input  logic [WORD_W-1:0] wdata,
    input  logic [WORD_W-1:0] evt,
    output logic [WORD_W-1:0] en_q,
    output logic [WORD_W-1:0] st_q,
    output logic              vint
);
    logic [WORD_W-1:0] en_set, en_clr, st_set, st_clr;
    logic [WORD_W-1:0] en_nxt, st_nxt;

    // Purpose: derive per-bit set and clear masks from the write.
    always_comb begin
        en_set = (wr_en && sel == SEL_EN_SET) ? wdata : '0;
        en_clr = (wr_en && sel == SEL_EN_CLR) ? wdata : '0;
        st_set = (wr_en && sel == SEL_ST_SET) ? wdata : '0;
        st_clr = (wr_en && sel == SEL_ST_CLR) ? wdata : '0;
        en_nxt = (en_q | en_set) & ~en_clr;
        // Events are applied last so they win over a same-cycle clear.
        st_nxt = ((st_q | st_set) & ~st_clr) | evt;
    end

    // Purpose: hold enable and status words, cleared by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q <= '0;
            st_q <= '0;
        end else begin
            en_q <= en_nxt;
            st_q <= st_nxt;
        end
    end

    assign vint = |(en_q & st_q);
endmodule

// File: rtl/vint_rdmux.sv
// Read path: selects the addressed group's word for a read hit and
// registers it; drives zero after any cycle without a read hit.
// Assumes: rd_hit already excludes reserved and out-of-range accesses.
module vint_rdmux
    import vint_pkg::*;
#(
    parameter int NUM_GROUPS = 4,
    parameter int GRP_W      = 8
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                rd_hit,
    input  logic [GRP_W-1:0]                    grp_field,
    input  reg_sel_e                            sel,
    input  logic [NUM_GROUPS-1:0][WORD_W-1:0]   en_all,
    input  logic [NUM_GROUPS-1:0][WORD_W-1:0]   st_all,
    output logic [WORD_W-1:0]                   rd_data
);
    logic [WORD_W-1:0] rd_nxt;

    // Purpose: pick the word addressed by the read.
    always_comb begin
        rd_nxt = '0;
        if (rd_hit) begin
            for (int g = 0; g < NUM_GROUPS; g++) begin
                if (grp_field == GRP_W'(g)) begin
                    case (sel)
                        SEL_EN_SET, SEL_EN_CLR: rd_nxt = en_all[g];
                        SEL_ST_SET, SEL_ST_CLR: rd_nxt = st_all[g];
                        SEL_MASKED:             rd_nxt = en_all[g] & st_all[g];
                        default:                rd_nxt = '0;
                    endcase
                end
            end
        end
    end

    // Purpose: register the read result for the next cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) rd_data <= '0;
        else        rd_data <= rd_nxt;
    end
endmodule

// File: rtl/vint_aggregator.sv
// Top: register bank of NUM_GROUPS virtual interrupt groups behind a
// region-selected register port, with per-bit event inputs and one
// level interrupt per group.
// Assumes: synchronous active-low reset; 64-bit aligned accesses.
module vint_aggregator
    import vint_pkg::*;
#(
    parameter int NUM_GROUPS = 4,
    parameter int ADDR_W     = 20,
    localparam int GRP_W     = ADDR_W - GRP_LSB,
    localparam int EVT_W     = NUM_GROUPS * WORD_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_valid,
    input  logic              acc_write,
    input  logic [1:0]        acc_region,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic [WORD_W-1:0] acc_wdata,
    input  logic [EVT_W-1:0]  evt_in,
    output logic [WORD_W-1:0] rd_data,
    output logic [NUM_GROUPS-1:0] vint_out
);
    logic                              wr_hit, rd_hit;
    logic [GRP_W-1:0]                  grp_field;
    reg_sel_e                          sel;
    logic [NUM_GROUPS-1:0]             wr_g;
    logic [NUM_GROUPS-1:0][WORD_W-1:0] grp_en;
    logic [NUM_GROUPS-1:0][WORD_W-1:0] grp_st;

    vint_decode #(.NUM_GROUPS(NUM_GROUPS), .ADDR_W(ADDR_W)) u_dec (
        .acc_valid (acc_valid),
        .acc_write (acc_write),
        .acc_region(acc_region),
        .acc_addr  (acc_addr),
        .wr_hit    (wr_hit),
        .rd_hit    (rd_hit),
        .grp_field (grp_field),
        .sel       (sel)
    );

    for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
        assign wr_g[g] = wr_hit && (grp_field == GRP_W'(g));

        vint_group u_grp (
            .clk  (clk),
            .rst_n(rst_n),
            .wr_en(wr_g[g]),
            .sel  (sel),
            .wdata(acc_wdata),
            .evt  (evt_in[g*WORD_W +: WORD_W]),
            .en_q (grp_en[g]),
            .st_q (grp_st[g]),
            .vint (vint_out[g])
        );
    end

    vint_rdmux #(.NUM_GROUPS(NUM_GROUPS), .GRP_W(GRP_W)) u_rd (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_hit   (rd_hit),
        .grp_field(grp_field),
        .sel      (sel),
        .en_all   (grp_en),
        .st_all   (grp_st),
        .rd_data  (rd_data)
    );
endmodule

// File: rtl/vint_aggregator_chk.sv
// Checker: temporal properties of the aggregator, bound to the top.
module vint_aggregator_chk
    import vint_pkg::*;
#(
    parameter int NUM_GROUPS = 4,
    parameter int ADDR_W     = 20
) (
    input logic                              clk,
    input logic                              rst_n,
    input logic                              acc_valid,
    input logic                              acc_write,
    input logic [1:0]                        acc_region,
    input logic [ADDR_W-1:0]                 acc_addr,
    input logic [NUM_GROUPS*WORD_W-1:0]      evt_in,
    input logic [WORD_W-1:0]                 rd_data,
    input logic [NUM_GROUPS-1:0]             vint_out,
    input logic [NUM_GROUPS-1:0][WORD_W-1:0] grp_en,
    input logic [NUM_GROUPS-1:0][WORD_W-1:0] grp_st
);
    logic rd_req, rsvd_off, far_grp;
    assign rd_req   = acc_valid && !acc_write;
    assign rsvd_off = (acc_addr[2:0] != 3'd0) || (acc_addr[11:6] != 6'd0)
                   || (acc_addr[5:3] > 3'd4);
    assign far_grp  = int'(acc_addr[ADDR_W-1:GRP_LSB]) >= NUM_GROUPS;

    assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (vint_out == '0 && rd_data == '0));

    assert_foreign_region_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && acc_region != REGION_CODE) |=> rd_data == '0);

    assert_enable_only_by_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(acc_valid && acc_write) |=> $stable(grp_en));

    assert_clear_never_sets_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_write && acc_addr[5:3] == 3'd1) |=> (grp_en & ~$past(grp_en)) == '0);

    assert_reserved_reads_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && rsvd_off) |=> rd_data == '0);

    assert_far_group_reads_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && far_grp) |=> rd_data == '0);

    for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_chk
        assert_event_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
            (evt_in[g*WORD_W +: WORD_W] != '0) |=>
            ((grp_st[g] & $past(evt_in[g*WORD_W +: WORD_W])) == $past(evt_in[g*WORD_W +: WORD_W])));
    end
endmodule

bind vint_aggregator vint_aggregator_chk #(.NUM_GROUPS(NUM_GROUPS), .ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/vint_aggregator_test.sv
module vint_aggregator_test;
    localparam int G  = 4;
    localparam int AW = 20;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            acc_valid = 1'b0;
    logic            acc_write = 1'b0;
    logic [1:0]      acc_region = 2'd0;
    logic [AW-1:0]   acc_addr = '0;
    logic [63:0]     acc_wdata = '0;
    logic [G*64-1:0] evt_in = '0;
    logic [63:0]     rd_data;
    logic [G-1:0]    vint_out;

    int    checks = 0;
    int    errors = 0;
    bit    done = 0;
    bit    live = 0;
    string cur_req = "R1";

    // Behavioural reference state.
    logic [63:0] m_en [G];
    logic [63:0] m_st [G];
    logic [63:0] m_rd;

    always #2.5 clk = ~clk;

    vint_aggregator #(.NUM_GROUPS(G), .ADDR_W(AW)) uut (
        .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
        .acc_region(acc_region), .acc_addr(acc_addr), .acc_wdata(acc_wdata),
        .evt_in(evt_in), .rd_data(rd_data), .vint_out(vint_out)
    );

    // Reference model, advanced on each rising edge.
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int g = 0; g < G; g++) begin m_en[g] = '0; m_st[g] = '0; end
            m_rd = '0;
        end else begin
            int grp, off;
            bit legal;
            grp   = int'(acc_addr[19:12]);
            off   = int'(acc_addr[11:0]);
            legal = acc_valid && acc_region == 2'd2 && grp < G &&
                    (off == 0 || off == 8 || off == 16 || off == 24 || off == 32);
            m_rd = '0;
            if (legal && !acc_write) begin
                if (off == 0 || off == 8)        m_rd = m_en[grp];
                else if (off == 16 || off == 24) m_rd = m_st[grp];
                else                             m_rd = m_en[grp] & m_st[grp];
            end
            if (legal && acc_write) begin
                if (off == 0)  m_en[grp] = m_en[grp] | acc_wdata;
                if (off == 8)  m_en[grp] = m_en[grp] & ~acc_wdata;
                if (off == 16) m_st[grp] = m_st[grp] | acc_wdata;
                if (off == 24) m_st[grp] = m_st[grp] & ~acc_wdata;
            end
            for (int g = 0; g < G; g++) m_st[g] = m_st[g] | evt_in[g*64 +: 64];
        end
    end

    // Per-cycle comparison, away from the active edge.
    always @(negedge clk) begin
        if (live && !done) begin
            logic [G-1:0] ev;
            for (int g = 0; g < G; g++) ev[g] = |(m_en[g] & m_st[g]);
            checks++;
            if (rd_data !== m_rd || vint_out !== ev) begin
                errors++;
                $display("FAIL %s per-cycle: rd_data %h vint %b expected %h / %b",
                         cur_req, rd_data, vint_out, m_rd, ev);
            end
        end
    end

    task automatic check64(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic access(input bit w, input logic [1:0] reg_code, input logic [AW-1:0] a,
                          input logic [63:0] d, input logic [G*64-1:0] ev);
        @(negedge clk);
        acc_valid = 1'b1; acc_write = w; acc_region = reg_code;
        acc_addr = a; acc_wdata = d; evt_in = ev;
        @(negedge clk);
        acc_valid = 1'b0; acc_write = 1'b0; evt_in = '0;
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [63:0] d);
        access(1'b1, 2'd2, a, d, '0);
    endtask

    task automatic rd_expect(input string tag, input logic [1:0] reg_code,
                             input logic [AW-1:0] a, input logic [63:0] exp);
        @(negedge clk);
        acc_valid = 1'b1; acc_write = 1'b0; acc_region = reg_code; acc_addr = a;
        @(negedge clk);
        check64(tag, rd_data, exp);
        acc_valid = 1'b0;
    endtask

    task automatic event_only(input logic [G*64-1:0] ev);
        @(negedge clk);
        evt_in = ev;
        @(negedge clk);
        evt_in = '0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        live = 1;
        // R1: reset state
        check64("R1 vint after reset", {60'd0, vint_out}, 64'd0);
        check64("R1 rd_data after reset", rd_data, 64'd0);
        rd_expect("R1 enable reads zero", 2'd2, 20'h00000, 64'd0);

        cur_req = "R3";
        wr(20'h00000, 64'h00FF);
        rd_expect("R3 enable via set offset", 2'd2, 20'h00000, 64'h00FF);
        rd_expect("R3 enable via clear offset", 2'd2, 20'h00008, 64'h00FF);
        wr(20'h00000, 64'h0F00);
        rd_expect("R3 zeros leave bits", 2'd2, 20'h00000, 64'h0FFF);

        cur_req = "R4";
        wr(20'h00008, 64'h000F);
        rd_expect("R4 clear offset", 2'd2, 20'h00000, 64'h0FF0);

        cur_req = "R5";
        wr(20'h00010, 64'h0011);
        rd_expect("R5 raw via set offset", 2'd2, 20'h00010, 64'h0011);
        rd_expect("R5 raw via clear offset", 2'd2, 20'h00018, 64'h0011);
        check64("R7 line high with masked bit", {63'd0, vint_out[0]}, 64'd1);

        cur_req = "R6";
        rd_expect("R6 masked view", 2'd2, 20'h00020, 64'h0010);
        wr(20'h00020, '1);
        rd_expect("R6 write to masked ignored", 2'd2, 20'h00020, 64'h0010);
        rd_expect("R6 raw unchanged", 2'd2, 20'h00010, 64'h0011);

        cur_req = "R7";
        wr(20'h00018, 64'h0010);
        check64("R7 line low when masked clear", {63'd0, vint_out[0]}, 64'd0);
        rd_expect("R5 clear leaves other bit", 2'd2, 20'h00010, 64'h0001);

        cur_req = "R2";
        access(1'b1, 2'd1, 20'h01000, '1, '0);
        access(1'b1, 2'd3, 20'h00008, '1, '0);
        rd_expect("R2 other region no write", 2'd2, 20'h01000, 64'd0);
        rd_expect("R2 other region read zero", 2'd3, 20'h00000, 64'd0);
        rd_expect("R2 enable intact", 2'd2, 20'h00000, 64'h0FF0);

        cur_req = "R8";
        wr(20'h00028, '1);
        wr(20'h00040, '1);
        wr(20'h00004, '1);
        wr(20'h0000C, '1);
        rd_expect("R8 reserved writes ignored", 2'd2, 20'h00000, 64'h0FF0);
        rd_expect("R8 reserved writes ignored st", 2'd2, 20'h00010, 64'h0001);
        rd_expect("R8 reserved read zero", 2'd2, 20'h00028, 64'd0);
        rd_expect("R8 misaligned read zero", 2'd2, 20'h00004, 64'd0);

        cur_req = "R9";
        wr(20'h04000, '1);
        wr(20'h04010, '1);
        rd_expect("R9 far group read zero", 2'd2, 20'h04000, 64'd0);
        rd_expect("R9 no alias onto group 0", 2'd2, 20'h00000, 64'h0FF0);
        rd_expect("R9 no alias status", 2'd2, 20'h00010, 64'h0001);

        cur_req = "R11";
        wr(20'h02000, 64'h000A);
        rd_expect("R11 group 2 by index", 2'd2, 20'h02000, 64'h000A);
        rd_expect("R11 group 1 untouched", 2'd2, 20'h01000, 64'd0);
        @(negedge clk);
        check64("R11 idle cycle reads zero", rd_data, 64'd0);

        cur_req = "R10";
        event_only({{(G*64-64){1'b0}}, 64'h0100});
        rd_expect("R10 event sets bit", 2'd2, 20'h00010, 64'h0101);
        check64("R10 line follows event", {63'd0, vint_out[0]}, 64'd1);
        access(1'b1, 2'd2, 20'h00018, 64'h0100, {{(G*64-64){1'b0}}, 64'h0100});
        rd_expect("R10 event beats clear", 2'd2, 20'h00010, 64'h0101);
        wr(20'h00018, 64'h0100);
        rd_expect("R10 clear alone works", 2'd2, 20'h00010, 64'h0001);
        event_only({64'h8000_0000_0000_0000, {(G*64-64){1'b0}}});
        rd_expect("R10 event top group", 2'd2, 20'h03010, 64'h8000_0000_0000_0000);

        // Mixed traffic, compared cycle by cycle against the model (R7/R11).
        cur_req = "R7/R11 mixed";
        for (int i = 0; i < 3000; i++) begin
            logic [AW-1:0] a;
            logic [63:0]   d;
            logic [G*64-1:0] ev;
            int pick;
            pick = int'($urandom_range(0, 7));
            a = {4'd0, 6'd0, 2'($urandom_range(0, 3)), 6'd0, 3'(pick > 5 ? 5 : pick), 3'd0};
            if ($urandom_range(0, 15) == 0) a[19:12] = 8'($urandom_range(4, 255));
            d = {$urandom, $urandom} & {$urandom, $urandom};
            ev = '0;
            if ($urandom_range(0, 3) == 0)
                ev[$urandom_range(0, G*64-1)] = 1'b1;
            @(negedge clk);
            acc_valid  = ($urandom_range(0, 3) != 0);
            acc_write  = $urandom_range(0, 1) == 1;
            acc_region = ($urandom_range(0, 7) == 0) ? 2'd1 : 2'd2;
            acc_addr   = a;
            acc_wdata  = d;
            evt_in     = ev;
        end
        @(negedge clk);
        acc_valid = 1'b0; evt_in = '0;
        repeat (2) @(negedge clk);

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule